// File: doc/BRIEF.md
# Shared Rate Timer Without Division

This block is the common time base for the periodic events of a sound-synthesis engine, such as envelope steps and noise updates. It runs freely and moves one step on every sample tick. In each cycle a consumer presents a 5-bit rate code, and the block answers with a single flag. The flag says whether the event for that rate is due on the current tick.

Every period has the form 2^n, 3·2^n or 5·2^n, and no divider or modulus logic is used to produce them. Three binary counters produce all of them. The first counter advances on every tick. The second sits behind a divide-by-3 prescaler and the third behind a divide-by-5 prescaler. The reset values of the three counters are fixed, and they set the phase of every rate. A rate fires when a chosen group of low bits of its counter are all ones. For the prescaled counters, the prescaler's last state serves as an extra least significant bit.

The flag is derived combinationally from the current counter state and the rate code. A consumer can therefore change the rate in any cycle without disturbing the counters. As a result, the first interval after a change can be shorter than the intervals that follow.

Top module: `shared_rate_timer`

## Requirements
- R1: The plain counter is 11 bits wide. It adds one on each cycle with tick_en high and wraps from 0x7FF to 0. Its reset value is 0x7FF. For rate 1 (period 2048), fire is high at tick count t exactly when t mod 2048 = 0, where t counts the ticks since reset.
- R2: The divide-by-3 prescaler counts 0,1,2 and steps its 9-bit counter only when it wraps from 2 to 0. The 9-bit counter wraps from 0x1FF. The divide-by-5 prescaler counts 0..4 and steps its 8-bit counter only when it wraps from 4 to 0. The 8-bit counter wraps from 0xFF. Rate 2 has period 1536 and rate 3 has period 1280.
- R3: A synchronous reset loads 0x7FF into the plain counter. It loads 0xA5 with prescaler 0 into the 9-bit counter, and 0x94 with prescaler 3 into the 8-bit counter. For rates 1 to 30 with period P, fire is therefore high at tick count t when (t + F) mod P = 0. F is 0 for a period that is a power of two, 496 for a period of the form 3·2^n, and 744 for a period of the form 5·2^n.
- R4: On a cycle with tick_en low, no counter or prescaler changes. The fire answer for every rate at the next cycle equals the answer at the current one.
- R5: Rate 31 fires on every cycle.
- R6: Rate 0 never fires.
- R7: Rates 30 down to 1 take the periods 2, 3, 4, 5, 6, 8, 10, 12, 16, 20, 24, 32, … 1024, 1280, 1536, 2048, in ascending order. These are the 30 values of the forms 2^n (n ≥ 1), 3·2^n and 5·2^n that do not exceed 2048. Consecutive ticks at rate 30 therefore alternate between firing and not firing.
- R8: fire follows rate_sel in the same cycle, with no register between them. The fire test for a rate is that its selected low bits of the chain are all ones. For 3·2^n and 5·2^n periods, the extended value is the counter shifted left by one. Its new least significant bit is high when the prescaler is in its last state.
- R9: Changing rate_sel never resets or shifts the counters. After a change, the new rate fires on the ticks given by R3 for the running tick count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Sample tick; the counters advance on cycles where it is high |
| rate_sel | input | 5 | Rate code to test; 0 never fires, 31 always fires |
| fire | output | 1 | High when the selected rate's event is due on the current tick |

## Verification
The fire answer is due in the same cycle that rate_sel is presented, since it is combinational. The effect of a tick appears one cycle later, after the rising edge at which tick_en was high. The bench therefore drives rate_sel and tick_en just after a falling edge and samples fire 5 ns later, before the next rising edge. It advances its own tick count only after an edge at which it drove tick_en high. Each sample is compared with a model that keeps a single tick count and applies the period and phase rule. The comparison runs over more than two full 30720-tick cycles of the combined counters.

// File: rtl/rc_pkg.sv
package rc_pkg;

   // source selector for one rate slot
   localparam int SRC_PLAIN = 0;
   localparam int SRC_BY3   = 1;
   localparam int SRC_BY5   = 2;
   localparam int SRC_ON    = 3;
   localparam int SRC_OFF   = 4;

   // Rate slot layout: the top code is always on, code 0 is always off.
   // The two codes below the top use one bit of the plain and by-3 chains;
   // from there on each group of three takes plain, by-5, by-3 in turn with
   // one more bit, so the periods come out in ascending order.
   function automatic int slot_src(input int r, input int top);
      int j;
      if (r == top)          return SRC_ON;
      else if (r == 0)       return SRC_OFF;
      else if (r == top - 1) return SRC_PLAIN;
      else if (r == top - 2) return SRC_BY3;
      j = (top - 3) - r;
      case (j % 3)
         0:       return SRC_PLAIN;
         1:       return SRC_BY5;
         default: return SRC_BY3;
      endcase
   endfunction

   // index of the highest bit tested for a slot
   function automatic int slot_msb(input int r, input int top);
      int j;
      if (r == top || r == 0)            return 0;
      else if (r == top - 1 || r == top - 2) return 0;
      j = (top - 3) - r;
      case (j % 3)
         1:       return j / 3;
         default: return j / 3 + 1;
      endcase
   endfunction

endpackage

// File: rtl/rc_binary_chain.sv
module rc_binary_chain #(
   parameter int          CNT_W    = 11,
   parameter logic [31:0] CNT_INIT = 32'h7FF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] INIT_V = CNT_W'(CNT_INIT);

   generate
      if (CNT_W < 1 || CNT_W > 31) begin : g_bad_width
         $error("rc_binary_chain: CNT_W out of range");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       cnt <= INIT_V;
      else if (tick) cnt <= cnt + 1'b1;
   end

   // R1
   plain_step_chk: assert property (@(posedge clk) disable iff (rst)
      tick |=> cnt == CNT_W'($past(cnt) + 1'b1));

   // R4
   plain_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt));

   // R3
   plain_reset_chk: assert property (@(posedge clk)
      rst |=> cnt == INIT_V);

endmodule

// File: rtl/rc_prescaled_chain.sv
module rc_prescaled_chain #(
   parameter int          CNT_W    = 9,
   parameter int          DIV      = 3,
   parameter logic [31:0] CNT_INIT = 32'hA5,
   parameter int          PRE_INIT = 0
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           tick,
   output logic [CNT_W:0] ext
);

   localparam int               PRE_W    = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);
   localparam logic [PRE_W-1:0] PRE_RST  = PRE_W'(PRE_INIT);
   localparam logic [CNT_W-1:0] CNT_RST  = CNT_W'(CNT_INIT);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("rc_prescaled_chain: DIV must be at least 2");
      end
      if (PRE_INIT < 0 || PRE_INIT >= DIV) begin : g_bad_pre
         $error("rc_prescaled_chain: PRE_INIT outside prescaler range");
      end
      if (CNT_W < 1 || CNT_W > 30) begin : g_bad_width
         $error("rc_prescaled_chain: CNT_W out of range");
      end
   endgenerate

   logic [PRE_W-1:0] pre;
   logic [CNT_W-1:0] cnt;
   logic             pre_wrap;

   assign pre_wrap = (pre == PRE_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         pre <= PRE_RST;
         cnt <= CNT_RST;
      end else if (tick) begin
         if (pre_wrap) begin
            pre <= '0;
            cnt <= cnt + 1'b1;
         end else begin
            pre <= pre + 1'b1;
         end
      end
   end

   // prescaler's last state acts as an extra low bit
   assign ext = {cnt, pre_wrap};

   // R2
   pre_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && pre == PRE_LAST) |=> (pre == '0 && cnt == CNT_W'($past(cnt) + 1'b1)));

   // R2
   pre_step_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && pre != PRE_LAST) |=> (pre == PRE_W'($past(pre) + 1'b1) && $stable(cnt)));

   // R2
   pre_range_chk: assert property (@(posedge clk) disable iff (rst)
      pre <= PRE_LAST);

   // R4
   pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !tick |=> ($stable(pre) && $stable(cnt)));

   // R3
   pre_reset_chk: assert property (@(posedge clk)
      rst |=> (pre == PRE_RST && cnt == CNT_RST));

endmodule

// File: rtl/rc_rate_decode.sv
module rc_rate_decode #(
   parameter int RATE_W = 5,
   parameter int A_W    = 11,
   parameter int B_W    = 10,
   parameter int C_W    = 9
) (
   input  logic [A_W-1:0]         a_val,
   input  logic [B_W-1:0]         b_ext,
   input  logic [C_W-1:0]         c_ext,
   output logic [2**RATE_W-1:0]   fire_vec
);
   import rc_pkg::*;

   localparam int N_RATE = 2 ** RATE_W;
   localparam int TOP    = N_RATE - 1;

   generate
      for (genvar r = 0; r < N_RATE; r++) begin : g_slot
         localparam int SRC = slot_src(r, TOP);
         localparam int MSB = slot_msb(r, TOP);
         if (SRC == SRC_ON) begin : g_on
            assign fire_vec[r] = 1'b1;
         end else if (SRC == SRC_OFF) begin : g_off
            assign fire_vec[r] = 1'b0;
         end else if (SRC == SRC_PLAIN) begin : g_plain
            localparam logic [A_W-1:0] M = A_W'((64'd1 << (MSB + 1)) - 64'd1);
            if (MSB >= A_W) begin : g_bad
               $error("rc_rate_decode: plain chain too narrow");
            end
            assign fire_vec[r] = ((a_val & M) == M);
         end else if (SRC == SRC_BY3) begin : g_by3
            localparam logic [B_W-1:0] M = B_W'((64'd1 << (MSB + 1)) - 64'd1);
            if (MSB >= B_W) begin : g_bad
               $error("rc_rate_decode: by-3 chain too narrow");
            end
            assign fire_vec[r] = ((b_ext & M) == M);
         end else begin : g_by5
            localparam logic [C_W-1:0] M = C_W'((64'd1 << (MSB + 1)) - 64'd1);
            if (MSB >= C_W) begin : g_bad
               $error("rc_rate_decode: by-5 chain too narrow");
            end
            assign fire_vec[r] = ((c_ext & M) == M);
         end
      end
   endgenerate

endmodule

// File: rtl/shared_rate_timer.sv
module shared_rate_timer #(
   parameter int          RATE_W     = 5,
   parameter int          A_W        = 11,
   parameter int          B_W        = 9,
   parameter int          C_W        = 8,
   parameter logic [31:0] A_INIT     = 32'h7FF,
   parameter logic [31:0] B_INIT     = 32'hA5,
   parameter int          B_PRE_INIT = 0,
   parameter logic [31:0] C_INIT     = 32'h94,
   parameter int          C_PRE_INIT = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_en,
   input  logic [RATE_W-1:0] rate_sel,
   output logic              fire
);

   localparam int N_RATE = 2 ** RATE_W;
   localparam int TOP    = N_RATE - 1;
   localparam int SLOTS  = A_W + (B_W + 1) + (C_W + 1);

   generate
      if (SLOTS != N_RATE - 2) begin : g_bad_slots
         $error("shared_rate_timer: chain widths do not fill the rate codes");
      end
      if (A_W != C_W + 3 || B_W != C_W + 1) begin : g_bad_ratio
         $error("shared_rate_timer: chain widths break ascending period order");
      end
   endgenerate

   logic [A_W-1:0]    a_val;
   logic [B_W:0]      b_ext;
   logic [C_W:0]      c_ext;
   logic [N_RATE-1:0] fire_vec;

   rc_binary_chain #(
      .CNT_W    (A_W),
      .CNT_INIT (A_INIT)
   ) u_plain (
      .clk  (clk),
      .rst  (rst),
      .tick (tick_en),
      .cnt  (a_val)
   );

   rc_prescaled_chain #(
      .CNT_W    (B_W),
      .DIV      (3),
      .CNT_INIT (B_INIT),
      .PRE_INIT (B_PRE_INIT)
   ) u_by3 (
      .clk  (clk),
      .rst  (rst),
      .tick (tick_en),
      .ext  (b_ext)
   );

   rc_prescaled_chain #(
      .CNT_W    (C_W),
      .DIV      (5),
      .CNT_INIT (C_INIT),
      .PRE_INIT (C_PRE_INIT)
   ) u_by5 (
      .clk  (clk),
      .rst  (rst),
      .tick (tick_en),
      .ext  (c_ext)
   );

   rc_rate_decode #(
      .RATE_W (RATE_W),
      .A_W    (A_W),
      .B_W    (B_W + 1),
      .C_W    (C_W + 1)
   ) u_decode (
      .a_val    (a_val),
      .b_ext    (b_ext),
      .c_ext    (c_ext),
      .fire_vec (fire_vec)
   );

   assign fire = fire_vec[rate_sel];

   // R5
   always_on_chk: assert property (@(posedge clk) disable iff (rst)
      (rate_sel == RATE_W'(TOP)) |-> fire);

   // R6
   never_fire_chk: assert property (@(posedge clk) disable iff (rst)
      (rate_sel == '0) |-> !fire);

   // R7
   fastest_alt_chk: assert property (@(posedge clk) disable iff (rst)
      (rate_sel == RATE_W'(TOP - 1) && tick_en && fire) ##1
      (rate_sel == RATE_W'(TOP - 1)) |-> !fire);

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!tick_en && $stable(rate_sel)) ##1 $stable(rate_sel) |-> $stable(fire));

endmodule

// File: tb/shared_rate_timer_tb.sv
module shared_rate_timer_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick_en = 1'b0;
   logic [4:0] rate_sel = 5'd0;
   logic       fire;

   int checks = 0;
   int failures = 0;
   int t = 0;
   int per_tab [32];
   int off_tab [32];

   shared_rate_timer u_dut (
      .clk      (clk),
      .rst      (rst),
      .tick_en  (tick_en),
      .rate_sel (rate_sel),
      .fire     (fire)
   );

   always #10 clk = ~clk;

   function automatic bit period_form(input int v);
      int o = v;
      while (o % 2 == 0) o = o / 2;
      return (o == 1 && v >= 2) || o == 3 || o == 5;
   endfunction

   function automatic bit model_fire(input int r, input int tc);
      if (r == 31) return 1'b1;
      if (r == 0)  return 1'b0;
      return ((tc + off_tab[r]) % per_tab[r]) == 0;
   endfunction

   task automatic build_tables();
      int r = 30;
      for (int i = 0; i < 32; i++) begin
         per_tab[i] = 1;
         off_tab[i] = 0;
      end
      for (int v = 2; v <= 2048; v++) begin
         if (period_form(v) && r >= 1) begin
            per_tab[r] = v;
            off_tab[r] = (v % 3 == 0) ? 496 : (v % 5 == 0) ? 744 : 0;
            r--;
         end
      end
   endtask

   task automatic check(input string tag, input int r);
      bit exp_v = model_fire(r, t);
      checks++;
      if (fire !== exp_v) begin
         failures++;
         $display("FAIL %s rate=%0d tick=%0d actual=%b expected=%b",
                  tag, r, t, fire, exp_v);
      end
   endtask

   // drive after falling edge, sample 5 ns later, count the tick after rising edge
   task automatic step(input int r, input bit en, input string tag);
      @(negedge clk);
      rate_sel = r[4:0];
      tick_en  = en;
      #5;
      check(tag, r);
      @(posedge clk);
      if (en) t++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      tick_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t = 0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      bit prev_en = 1'b1;
      void'($urandom(32'd20240517));
      build_tables();
      do_reset();

      // R3: phase of every rate right after reset, no ticks
      for (int r = 0; r < 32; r++) step(r, 1'b0, "R3");
      // R3: first few ticks of the rates that carry offsets
      for (int k = 0; k < 12; k++) step(29 - (k % 4) * 1, 1'b1, "R3");

      // R1: plain chain, rate 1 over a full wrap
      for (int k = 0; k < 2100; k++) step(1, 1'b1, "R1");
      // R2: by-3 and by-5 chains
      for (int k = 0; k < 1600; k++) step(2, 1'b1, "R2");
      for (int k = 0; k < 1300; k++) step(3, 1'b1, "R2");

      // R9: switch rate mid-period, counters keep running
      for (int k = 0; k < 700; k++) step(1, 1'b1, "R9");
      for (int k = 0; k < 1600; k++) step(2, 1'b1, "R9");
      for (int k = 0; k < 40; k++) step(26 - (k % 7), 1'b1, "R9");

      // R8: same-cycle response to rate code with no tick
      for (int r = 0; r < 32; r++) step(r, 1'b0, "R8");

      // random run over two full combined cycles
      while (t < 2 * 30720 + 200) begin
         int r = $urandom % 32;
         bit en = ($urandom % 4) != 0;
         string tag;
         if (r == 31)       tag = "R5";
         else if (r == 0)   tag = "R6";
         else if (!prev_en) tag = "R4";
         else               tag = "R7";
         step(r, en, tag);
         prev_en = en;
      end

      // R4: long idle stretch, answers must not move
      for (int k = 0; k < 64; k++) step(k % 32, 1'b0, "R4");

      // R3: reset in mid-run restores the phases
      do_reset();
      for (int r = 0; r < 32; r++) step(r, 1'b0, "R3");
      for (int k = 0; k < 30; k++) step(30 - k, 1'b1, "R3");

      // R5 / R6 directed
      for (int k = 0; k < 8; k++) step(31, 1'b1, "R5");
      for (int k = 0; k < 8; k++) step(0, 1'b1, "R6");

      finish_run();
   end

endmodule